// File: doc/BRIEF.md
# Dual-Polynomial Signature Compactor

This block squeezes the parallel response of a circuit under test into a single K-bit signature by polynomial division. On every cycle with capture asserted, the register advances by one step of an internal-XOR (modular) shift register and folds in the whole response word: bit i of the word enters stage i. Because the operation is linear, the final signature is the XOR of the remainders left by dividing each output stream separately by the feedback polynomial.

Two feedback polynomials are available. A select bit drives a 2:1 multiplexer in front of the tap XOR gates. A full test runs two epochs. The first epoch uses polynomial A. Then the register is reseeded and a second epoch runs with polynomial B. At the end of each epoch a done strobe compares the register with the golden signature for the polynomial in use. The block reports pass only when both epochs matched, which makes aliasing much less likely: a fault that aliases under one polynomial rarely aliases under the other. The golden values come from outside the block.

A clear with the select bit low is a full clear: it reseeds the register and wipes both epoch results. A clear with the select bit high only reseeds the register, so the result of epoch A is kept while epoch B runs.

Top module: `dual_sig_compactor`

## Requirements
- R1: After reset, pass and fail are both 0 and the register holds the all-zero seed.
- R2: A cycle with clear high loads the seed value 0 into the register. A done issued right after it matches a golden value of 0.
- R3: On a cycle with capture high and clear low, the register becomes next = {s[K-2:0],0} XOR (s[K-1] ? taps : 0) XOR resp. Here taps bit j is the coefficient of x^j in the selected polynomial.
- R4: On cycles with capture and clear both low, the register holds its value, so idle gaps between captures do not change the final signature.
- R5: The select bit picks the taps: 0 selects polynomial A (default 1 + x^2 + x^7 + x^8, taps 8'h85) and 1 selects polynomial B (default 1 + x^2 + x^3 + x^4 + x^8, taps 8'h1D).
- R6: A done with clear low compares the register with goldenA when the select bit is 0, or with goldenB when it is 1. The outcome shows on pass and fail from the next clock. Done is given one cycle after the last capture of the epoch.
- R7: Pass is 1 only after both an epoch-A done and an epoch-B done have matched, with no mismatch recorded since the last full clear.
- R8: Any mismatch sets fail, and fail stays set until a full clear. A full clear is a clear with the select bit 0. A clear with the select bit 1 reseeds the register and keeps the verdict state.
- R9: Clear takes priority over capture and done in the same cycle: the register goes to the seed and no comparison is recorded.
- R10: The final signature equals the XOR of the signatures each single response bit stream would produce on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Reseed the register. With polySel low, also wipe the epoch results |
| capture | input | 1 | Fold resp into the signature this cycle |
| resp | input | K | Parallel response word from the circuit under test |
| polySel | input | 1 | 0 selects polynomial A, 1 selects polynomial B |
| goldenA | input | K | Good-machine signature for polynomial A |
| goldenB | input | K | Good-machine signature for polynomial B |
| done | input | 1 | End of epoch: compare the register with the selected golden value |
| pass | output | 1 | Both epochs matched |
| fail | output | 1 | Sticky mismatch flag |

## Verification
Random response streams of random lengths, with random idle gaps between captures, are compacted in both epochs. Each run has a correct golden value, or a golden value corrupted in epoch A, in epoch B or in both. This separates the tap arithmetic, the hold behaviour and the two-epoch verdict logic.

A directed stream of 8'h80 followed by 8'h00 leaves 8'h85 under A and 8'h1D under B, which shows that the multiplexer really switches taps. A golden value built from per-bit streams shows that all response bits are superposed. A cycle that raises clear, capture and done together, and empty epochs checked against zero, pin down the seed and the priority rules.

// File: rtl/sig_cmp_pkg.sv
`timescale 1ns/1ps
package sig_cmp_pkg;
  // Strobes issued by the control to the datapath for one clock.
  typedef struct packed {
    logic seedLoad;
    logic shiftEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/sig_cmp_datapath.sv
`timescale 1ns/1ps
module sig_cmp_datapath
  import sig_cmp_pkg::*;
#(
  parameter int K = 8,
  parameter logic [K-1:0] POLY_A = 8'h85,
  parameter logic [K-1:0] POLY_B = 8'h1D,
  parameter logic [K-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t strobes,
  input  logic         polySel,
  input  logic [K-1:0] resp,
  input  logic [K-1:0] goldenA,
  input  logic [K-1:0] goldenB,
  output logic [K-1:0] sigQ,
  output logic         match
);
  localparam int TOP = K - 1;

  logic [K-1:0] taps;
  logic [K-1:0] shifted;

  // 2:1 tap multiplexer: the only cost of the second polynomial.
  assign taps = polySel ? POLY_B : POLY_A;

  // Internal-XOR step: the top stage feeds back into every tapped stage.
  for (genvar i = 0; i < K; i++) begin : g_stage
    if (i == 0) begin : g_low
      assign shifted[i] = taps[i] & sigQ[TOP];
    end else begin : g_mid
      assign shifted[i] = sigQ[i-1] ^ (taps[i] & sigQ[TOP]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sigQ <= SEED;
    end else if (strobes.seedLoad) begin
      sigQ <= SEED;
    end else if (strobes.shiftEn) begin
      sigQ <= shifted ^ resp;
    end
  end

  assign match = (sigQ == (polySel ? goldenB : goldenA));
endmodule

// File: rtl/sig_cmp_ctrl.sv
`timescale 1ns/1ps
module sig_cmp_ctrl
  import sig_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic         done,
  input  logic         polySel,
  input  logic         match,
  output ctrlStrobes_t strobes,
  output logic         pass,
  output logic         fail
);
  logic evalEn;
  logic wipe;
  logic seenA, seenB, okA, okB, failQ;

  assign evalEn = done & ~clear;
  assign wipe   = clear & ~polySel;

  always_comb begin
    strobes.seedLoad = clear;
    strobes.shiftEn  = capture & ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenA <= 1'b0;
      seenB <= 1'b0;
      okA   <= 1'b0;
      okB   <= 1'b0;
      failQ <= 1'b0;
    end else if (wipe) begin
      seenA <= 1'b0;
      seenB <= 1'b0;
      okA   <= 1'b0;
      okB   <= 1'b0;
      failQ <= 1'b0;
    end else if (evalEn) begin
      if (polySel) begin
        seenB <= 1'b1;
        okB   <= match;
      end else begin
        seenA <= 1'b1;
        okA   <= match;
      end
      if (!match) failQ <= 1'b1;
    end
  end

  assign pass = seenA & seenB & okA & okB & ~failQ;
  assign fail = failQ;
endmodule

// File: rtl/dual_sig_compactor.sv
`timescale 1ns/1ps
module dual_sig_compactor
  import sig_cmp_pkg::*;
#(
  parameter int K = 8,
  parameter logic [K-1:0] POLY_A = 8'h85,
  parameter logic [K-1:0] POLY_B = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic [K-1:0] resp,
  input  logic         polySel,
  input  logic [K-1:0] goldenA,
  input  logic [K-1:0] goldenB,
  input  logic         done,
  output logic         pass,
  output logic         fail
);
  ctrlStrobes_t strobes;
  logic         match;
  logic [K-1:0] sigState;

  sig_cmp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture),
    .done(done), .polySel(polySel), .match(match),
    .strobes(strobes), .pass(pass), .fail(fail)
  );

  sig_cmp_datapath #(.K(K), .POLY_A(POLY_A), .POLY_B(POLY_B)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .polySel(polySel),
    .resp(resp), .goldenA(goldenA), .goldenB(goldenB),
    .sigQ(sigState), .match(match)
  );
endmodule

// File: rtl/dual_sig_compactor_chk.sv
`timescale 1ns/1ps
module dual_sig_compactor_chk #(
  parameter int K = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         capture,
  input logic         done,
  input logic         polySel,
  input logic         pass,
  input logic         fail,
  input logic [K-1:0] sigState
);
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sigState == '0));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> $stable(sigState));

  a_r6_verdict_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !clear) |=> ($stable(pass) && $stable(fail)));

  a_r7_pass_excludes_fail: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !fail);

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(clear && !polySel)) |=> fail);

  a_r9_full_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !polySel) |=> (!pass && !fail));
endmodule

bind dual_sig_compactor dual_sig_compactor_chk #(.K(K)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture), .done(done),
  .polySel(polySel), .pass(pass), .fail(fail), .sigState(sigState)
);

// File: tb/dual_sig_compactor_tb_top.sv
`timescale 1ns/1ps
module dual_sig_compactor_tb_top;
  localparam int K = 8;
  localparam logic [K-1:0] PA = 8'h85;
  localparam logic [K-1:0] PB = 8'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, capture = 1'b0, done = 1'b0, polySel = 1'b0;
  logic [K-1:0] resp = '0, goldenA = '0, goldenB = '0;
  logic pass, fail;
  int checks = 0;
  int fails = 0;
  logic [K-1:0] buf_q [16];

  always #10 clk = ~clk;

  dual_sig_compactor #(.K(K), .POLY_A(PA), .POLY_B(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture), .resp(resp),
    .polySel(polySel), .goldenA(goldenA), .goldenB(goldenB), .done(done),
    .pass(pass), .fail(fail)
  );

  function automatic logic [K-1:0] stepF(input logic [K-1:0] s, input logic [K-1:0] d,
                                         input logic sel);
    logic [K-1:0] h;
    h = sel ? PB : PA;
    return ({s[K-2:0], 1'b0} ^ (s[K-1] ? h : '0)) ^ d;
  endfunction

  function automatic logic [K-1:0] runBuf(input logic sel, input logic [K-1:0] mask,
                                          input int n);
    logic [K-1:0] s;
    s = '0;
    for (int i = 0; i < n; i++) s = stepF(s, buf_q[i] & mask, sel);
    return s;
  endfunction

  task automatic check(input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply inputs for one clock; returns at the following falling edge.
  task automatic tick(input logic c, input logic cap, input logic dn, input logic sel,
                      input logic [K-1:0] d);
    clear = c; capture = cap; done = dn; polySel = sel; resp = d;
    @(negedge clk);
  endtask

  task automatic idle(input logic sel);
    tick(1'b0, 1'b0, 1'b0, sel, $urandom);
  endtask

  // Two-epoch run over random data with optional golden corruption.
  task automatic twoEpochs(input int nA, input int nB, input logic [K-1:0] corA,
                           input logic [K-1:0] corB);
    logic [K-1:0] m;
    logic [K-1:0] d;
    logic okAll;
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R8 full clear drops fail", {7'b0, fail}, '0);
    m = '0;
    for (int i = 0; i < nA; i++) begin
      d = $urandom;
      tick(1'b0, 1'b1, 1'b0, 1'b0, d);
      m = stepF(m, d, 1'b0);
      for (int g = 0; g < int'($urandom % 3); g++) idle(1'b0); // R4 gaps
    end
    goldenA = m ^ corA;
    tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R6 epoch A fail", {7'b0, fail}, {7'b0, corA != 0});
    check("R7 no pass after one epoch", {7'b0, pass}, '0);
    tick(1'b1, 1'b0, 1'b0, 1'b1, '0);
    check("R8 partial clear keeps fail", {7'b0, fail}, {7'b0, corA != 0});
    m = '0;
    for (int i = 0; i < nB; i++) begin
      d = $urandom;
      tick(1'b0, 1'b1, 1'b0, 1'b1, d);
      m = stepF(m, d, 1'b1);
      for (int g = 0; g < int'($urandom % 3); g++) idle(1'b1);
    end
    goldenB = m ^ corB;
    tick(1'b0, 1'b0, 1'b1, 1'b1, '0);
    okAll = (corA == 0) && (corB == 0);
    check("R3 R5 R7 two-epoch pass", {7'b0, pass}, {7'b0, okAll});
    check("R8 two-epoch fail", {7'b0, fail}, {7'b0, !okAll});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pass", {7'b0, pass}, '0);
    check("R1 reset fail", {7'b0, fail}, '0);

    // R2: empty epochs against zero golden values.
    goldenA = '0; goldenB = '0;
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, 1'b0, 1'b1, '0);
    tick(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R2 seed matches zero", {7'b0, pass}, 8'h01);

    // R5: 80 then 00 gives 85 under A and 1D under B.
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h80);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    goldenA = 8'h85;
    tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R5 poly A taps", {7'b0, fail}, '0);
    tick(1'b1, 1'b0, 1'b0, 1'b1, '0);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 8'h80);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    goldenB = 8'h85;
    tick(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R5 poly B differs from A", {7'b0, fail}, 8'h01);

    // R9: clear wins over capture and done; then empty epochs pass.
    goldenA = '0; goldenB = '0;
    tick(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
    check("R9 clear priority fail", {7'b0, fail}, '0);
    check("R9 clear priority pass", {7'b0, pass}, '0);
    tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b0, 1'b1, 8'h5A);
    tick(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R9 capture ignored under clear", {7'b0, pass}, 8'h01);

    // R10: superposition of single-bit streams.
    for (int i = 0; i < 16; i++) buf_q[i] = $urandom;
    goldenA = '0; goldenB = '0;
    for (int j = 0; j < K; j++) begin
      goldenA ^= runBuf(1'b0, K'(1) << j, 16);
      goldenB ^= runBuf(1'b1, K'(1) << j, 16);
    end
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 16; i++) tick(1'b0, 1'b1, 1'b0, 1'b0, buf_q[i]);
    tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, 1'b0, 1'b1, '0);
    for (int i = 0; i < 16; i++) tick(1'b0, 1'b1, 1'b0, 1'b1, buf_q[i]);
    tick(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R10 superposition", {7'b0, pass}, 8'h01);

    // Directed corruption cases, then random runs.
    twoEpochs(5, 7, 8'h00, 8'h00);
    twoEpochs(6, 4, 8'h01, 8'h00);
    twoEpochs(3, 9, 8'h00, 8'h80);
    for (int it = 0; it < 24; it++) begin
      twoEpochs(1 + int'($urandom % 20), 1 + int'($urandom % 20),
                ($urandom % 3 == 0) ? K'(1 + $urandom % 255) : '0,
                ($urandom % 3 == 0) ? K'(1 + $urandom % 255) : '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule